// File: doc/BRIEF.md
# Masked Field Error Interrupt Generator

This block produces an active-low interrupt level for a video error-checking datapath. After the outgoing error packet of a field has been sent, it compares that field's 15 outgoing error flags with a sensitivity mask. The errored field counter uses the same mask, so both see the same errors. When any enabled flag is set, the interrupt goes low.

The output is a logical level. The open-drain pad and its pull-up are outside the block. A packet-exit strobe marks the point where the outgoing packet has left. A packet-entry strobe marks the arrival of the next packet. The block samples flags only at an exit strobe that follows an entry, or the first exit after reset. An exit seen while the window is already open is treated as spurious and ignored.

In latching (sticky) mode each enabled errored flag is recorded in a pending bit. A host read of a flag, given by its index, clears that one bit. The interrupt releases only when no pending bit is left.

Top module: `field_err_irq`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `irq_n` is 1, the window is closed and no flag is pending.
- R2: In live mode (`sticky_en`=0), an accepted exit strobe sets `irq_n` on the next cycle to 0 if `err_flags & sens_mask` is non-zero, and to 1 otherwise.
- R3: A flag whose mask bit is 0 never drives `irq_n` low, in either mode. Flag index k is bit k of `err_flags`, `sens_mask` and the pending set.
- R4: In live mode `irq_n` changes only on the cycle after an accepted exit strobe. Changes of flags, mask, entry strobe or host reads at other times leave it unchanged.
- R5: An exit strobe is accepted only when the window is closed. The window is closed after reset, opened by an accepted exit, and closed by `pkt_entry`. A second exit with no entry in between is ignored.
- R6: In sticky mode (`sticky_en`=1), an accepted exit adds every bit of `err_flags & sens_mask` to the pending set. Pending bits accumulate across fields, and `irq_n` is 0 on the next cycle whenever the set is non-empty.
- R7: In sticky mode a host read (`host_rd`=1) with index `rd_idx`=k clears pending bit k. `irq_n` returns to 1 on the cycle after the last pending bit is read. A read of a bit that is not pending, or of an index of 15 or more, changes nothing.
- R8: When an accepted exit sets a bit and a host read clears the same bit in the same cycle, the bit stays pending.
- R9: In live mode the pending set is held empty. On the cycle after `sticky_en` rises, `irq_n` follows the (empty) pending set and reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_flags | input | 15 | Outgoing error flags of the current field |
| sens_mask | input | 15 | Sensitivity mask shared with the errored field counter |
| sticky_en | input | 1 | 1 selects latching mode, 0 selects live mode |
| pkt_exit | input | 1 | One-cycle strobe: outgoing error packet has left |
| pkt_entry | input | 1 | One-cycle strobe: next error packet is entering |
| host_rd | input | 1 | One-cycle strobe: host has read one flag |
| rd_idx | input | 4 | Index of the flag read by the host |
| irq_n | output | 1 | Active-low interrupt level |

## Verification
Every result is registered once. An accepted exit, a host read or a rise of `sticky_en` shows on `irq_n` one clock later, and no other path exists. The bench drives each stimulus on a falling edge and holds it across exactly one rising edge. It then reads `irq_n` on the following falling edge, which is the first sample after that one register has updated. Hold and ignore checks use the same sampling, but only after several extra cycles of changing stimulus, so a late or wrong change would be seen.

// File: rtl/fei_pkg.sv
// Package: shared constants and mode encoding for the field error interrupt.
// Assumes: one flag per bit, 15 flags per field.
package fei_pkg;
    localparam int unsigned FLAG_COUNT = 15;

    typedef enum logic {
        MODE_LIVE  = 1'b0,
        MODE_LATCH = 1'b1
    } irq_mode_e;
endpackage

// File: rtl/fei_window.sv
// Module: tracks the window between packet exit and the next packet entry.
// It accepts an exit strobe only when the window is closed.
// Assumes: strobes last one cycle; exit wins over entry in the same cycle.
module fei_window (
    input  logic clk,
    input  logic rst_n,
    input  logic pkt_exit,
    input  logic pkt_entry,
    output logic capture,
    output logic win_open
);
    assign capture = pkt_exit && !win_open;

    // Window state: opened by an accepted exit, closed by an entry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            win_open <= 1'b0;
        else if (capture)
            win_open <= 1'b1;
        else if (pkt_entry)
            win_open <= 1'b0;
    end

    AST_DUP_EXIT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && !pkt_entry) |=> win_open); // R5
endmodule

// File: rtl/fei_flag_gate.sv
// Module: applies the sensitivity mask to the flags and decodes the host read
// index into a one-hot clear vector.
// Assumes: an index outside the flag range decodes to no clear.
module fei_flag_gate #(
    parameter int unsigned NUM_FLAGS = fei_pkg::FLAG_COUNT,
    localparam int unsigned IDX_W = $clog2(NUM_FLAGS + 1)
) (
    input  logic [NUM_FLAGS-1:0] flags,
    input  logic [NUM_FLAGS-1:0] mask,
    input  logic                 rd,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [NUM_FLAGS-1:0] hits,
    output logic                 any_hit,
    output logic [NUM_FLAGS-1:0] rd_clr
);
    // Masked error flags and their reduction.
    always_comb begin
        hits    = flags & mask;
        any_hit = |hits;
    end

    // One clear line per flag, set when the host reads that index.
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_clr
        assign rd_clr[g] = rd && (rd_idx == IDX_W'(g));
    end

    always_comb begin
        assert ($onehot0(rd_clr)) else $error("AST_CLR_ONEHOT"); // R7
    end
endmodule

// File: rtl/fei_pending.sv
// Module: pending set for latching mode. Captured hits are ORed in and host
// reads clear single bits. A capture beats a read of the same bit.
// Assumes: the set is held empty in live mode.
module fei_pending #(
    parameter int unsigned NUM_FLAGS = fei_pkg::FLAG_COUNT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  fei_pkg::irq_mode_e   mode,
    input  logic                 capture,
    input  logic [NUM_FLAGS-1:0] hits,
    input  logic [NUM_FLAGS-1:0] rd_clr,
    output logic [NUM_FLAGS-1:0] pend_q,
    output logic                 pend_any_d
);
    logic [NUM_FLAGS-1:0] pend_d;

    // Next pending set: clear read bits, then add this field's hits.
    always_comb begin
        if (mode == fei_pkg::MODE_LATCH)
            pend_d = (pend_q & ~rd_clr) | (capture ? hits : '0);
        else
            pend_d = '0;
        pend_any_d = |pend_d;
    end

    // Pending register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else
            pend_q <= pend_d;
    end

    AST_LIVE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == fei_pkg::MODE_LIVE) |=> (pend_q == '0)); // R9
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == fei_pkg::MODE_LATCH && capture && |(hits & rd_clr)) |=> (pend_q != '0)); // R8
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == fei_pkg::MODE_LATCH && !capture && rd_clr != '0) |=> ((pend_q & $past(rd_clr)) == '0)); // R7
    AST_NO_SPONTANEOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture) |=> ((pend_q & ~$past(pend_q)) == '0)); // R6
endmodule

// File: rtl/fei_level.sv
// Module: output register for the active-low interrupt level.
// Live mode updates it only on an accepted exit; latching mode follows the
// next pending set every cycle.
// Assumes: inputs come from the window and pending logic of the same field.
module fei_level (
    input  logic               clk,
    input  logic               rst_n,
    input  fei_pkg::irq_mode_e mode,
    input  logic               capture,
    input  logic               any_hit,
    input  logic               pend_any_d,
    output logic               irq_n
);
    // Interrupt level register, deasserted (high) in reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_n <= 1'b1;
        else if (mode == fei_pkg::MODE_LATCH)
            irq_n <= !pend_any_d;
        else if (capture)
            irq_n <= !any_hit;
    end

    AST_RESET_HIGH: assert property (@(posedge clk)
        !rst_n |=> irq_n); // R1
    AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == fei_pkg::MODE_LIVE && !capture) |=> $stable(irq_n)); // R4
    AST_LIVE_NO_HIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == fei_pkg::MODE_LIVE && capture && !any_hit) |=> irq_n); // R3
    AST_LIVE_HIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == fei_pkg::MODE_LIVE && capture && any_hit) |=> !irq_n); // R2
endmodule

// File: rtl/field_err_irq.sv
// Module: top of the masked field error interrupt generator.
// It ties together the window tracking, the flag masking and read decoding,
// the pending set and the output register.
// Assumes: all strobes are one cycle wide and synchronous to clk.
module field_err_irq #(
    parameter int unsigned NUM_FLAGS = fei_pkg::FLAG_COUNT,
    localparam int unsigned IDX_W = $clog2(NUM_FLAGS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] err_flags,
    input  logic [NUM_FLAGS-1:0] sens_mask,
    input  logic                 sticky_en,
    input  logic                 pkt_exit,
    input  logic                 pkt_entry,
    input  logic                 host_rd,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic                 irq_n
);
    fei_pkg::irq_mode_e   mode;
    logic                 capture;
    logic                 win_open;
    logic [NUM_FLAGS-1:0] hits;
    logic                 any_hit;
    logic [NUM_FLAGS-1:0] rd_clr;
    logic [NUM_FLAGS-1:0] pend_q;
    logic                 pend_any_d;

    assign mode = sticky_en ? fei_pkg::MODE_LATCH : fei_pkg::MODE_LIVE;

    fei_window u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .pkt_exit  (pkt_exit),
        .pkt_entry (pkt_entry),
        .capture   (capture),
        .win_open  (win_open)
    );

    fei_flag_gate #(.NUM_FLAGS(NUM_FLAGS)) u_gate (
        .flags   (err_flags),
        .mask    (sens_mask),
        .rd      (host_rd),
        .rd_idx  (rd_idx),
        .hits    (hits),
        .any_hit (any_hit),
        .rd_clr  (rd_clr)
    );

    fei_pending #(.NUM_FLAGS(NUM_FLAGS)) u_pending (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .capture    (capture),
        .hits       (hits),
        .rd_clr     (rd_clr),
        .pend_q     (pend_q),
        .pend_any_d (pend_any_d)
    );

    fei_level u_level (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .capture    (capture),
        .any_hit    (any_hit),
        .pend_any_d (pend_any_d),
        .irq_n      (irq_n)
    );

    AST_STICKY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_en && capture && any_hit) |=> !irq_n); // R6
    AST_WINDOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!sticky_en && win_open && !pkt_entry) |=> $stable(irq_n)); // R5
    AST_PENDING_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_en && $past(sticky_en)) |-> (irq_n == (pend_q == '0))); // R7
endmodule

// File: tb/field_err_irq_tb.sv
module field_err_irq_tb_top;
    localparam int NF = 15;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NF-1:0] err_flags;
    logic [NF-1:0] sens_mask;
    logic          sticky_en;
    logic          pkt_exit;
    logic          pkt_entry;
    logic          host_rd;
    logic [3:0]    rd_idx;
    logic          irq_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    field_err_irq dut_i (
        .clk(clk), .rst_n(rst_n), .err_flags(err_flags), .sens_mask(sens_mask),
        .sticky_en(sticky_en), .pkt_exit(pkt_exit), .pkt_entry(pkt_entry),
        .host_rd(host_rd), .rd_idx(rd_idx), .irq_n(irq_n)
    );

    task automatic chk(input string tag, input logic exp);
        checks++;
        if (irq_n !== exp) begin
            failures++;
            $display("FAIL %s: irq_n=%b expected=%b", tag, irq_n, exp);
        end
    endtask

    // Entry strobe, then exit strobe with the given flags and mask.
    task automatic field(input logic [NF-1:0] f, input logic [NF-1:0] m);
        @(negedge clk) pkt_entry = 1'b1;
        @(negedge clk) pkt_entry = 1'b0;
        err_flags = f; sens_mask = m; pkt_exit = 1'b1;
        @(negedge clk) pkt_exit = 1'b0;
    endtask

    task automatic hread(input logic [3:0] i);
        @(negedge clk) host_rd = 1'b1; rd_idx = i;
        @(negedge clk) host_rd = 1'b0;
    endtask

    initial begin
        logic [31:0] lf;
        logic [NF-1:0] f, m;
        rst_n = 1'b0; err_flags = '0; sens_mask = '0; sticky_en = 1'b0;
        pkt_exit = 1'b0; pkt_entry = 1'b0; host_rd = 1'b0; rd_idx = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset level", 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 1'b1);

        // R2/R3: single-flag sweep with mask bit on and off.
        for (int i = 0; i < NF; i++) begin
            field(NF'(1) << i, NF'(1) << i);
            chk($sformatf("R2 flag %0d enabled", i), 1'b0);
            field(NF'(1) << i, ~(NF'(1) << i));
            chk($sformatf("R3 flag %0d masked", i), 1'b1);
        end

        // R2: pseudo-random patterns, expected level computed arithmetically.
        lf = 32'h1234_5679;
        for (int n = 0; n < 300; n++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            f = lf[NF-1:0];
            m = lf[NF+15:16] & (n[0] ? lf[30:16] : 15'h7fff);
            field(f, m);
            chk($sformatf("R2 pattern %0d", n), ((f & m) == '0));
        end

        // R4: output low, then wiggle everything except an accepted exit.
        field(15'h0010, 15'h0010);
        chk("R4 setup low", 1'b0);
        @(negedge clk) err_flags = '0; sens_mask = '0; host_rd = 1'b1; rd_idx = 4'd4;
        @(negedge clk) host_rd = 1'b0; pkt_entry = 1'b1;
        @(negedge clk) pkt_entry = 1'b0; sens_mask = '1; err_flags = '1;
        @(negedge clk);
        chk("R4 held low", 1'b0);
        field(15'h0000, 15'h7fff);
        chk("R4 setup high", 1'b1);
        @(negedge clk) err_flags = '1; sens_mask = '1; host_rd = 1'b1; rd_idx = 4'd0;
        @(negedge clk) host_rd = 1'b0; pkt_entry = 1'b1;
        @(negedge clk) pkt_entry = 1'b0;
        @(negedge clk);
        chk("R4 held high", 1'b1);

        // R5: exit without entry is ignored.
        field(15'h0001, 15'h0001);
        chk("R5 first exit", 1'b0);
        @(negedge clk) err_flags = '0; pkt_exit = 1'b1;
        @(negedge clk) pkt_exit = 1'b0;
        @(negedge clk);
        chk("R5 duplicate exit ignored", 1'b0);
        field(15'h0000, 15'h0001);
        chk("R5 exit after entry accepted", 1'b1);

        // R9: switching to sticky mode with empty pending releases.
        field(15'h0100, 15'h0100);
        chk("R9 live low", 1'b0);
        @(negedge clk) sticky_en = 1'b1;
        @(negedge clk);
        chk("R9 sticky empty high", 1'b1);

        // R6/R7: per-flag sticky capture and clear sweep.
        for (int i = 0; i < NF; i++) begin
            field(NF'(1) << i, 15'h7fff);
            chk($sformatf("R6 sticky flag %0d", i), 1'b0);
            field(15'h0000, 15'h7fff);
            chk($sformatf("R6 sticky held %0d", i), 1'b0);
            hread(4'((i + 1) % NF));
            chk($sformatf("R7 other read %0d", i), 1'b0);
            hread(4'd15);
            chk($sformatf("R7 index 15 read %0d", i), 1'b0);
            hread(4'(i));
            chk($sformatf("R7 own read %0d", i), 1'b1);
        end

        // R3 in sticky mode: masked flags never pend.
        field(15'h7ffe, 15'h0001);
        chk("R3 sticky masked", 1'b1);

        // R6: accumulation over two fields, release after last read.
        field(15'h0005, 15'h7fff);
        field(15'h0200, 15'h7fff);
        hread(4'd0);
        chk("R6 after read 0", 1'b0);
        hread(4'd2);
        chk("R6 after read 2", 1'b0);
        hread(4'd9);
        chk("R7 after last read", 1'b1);

        // R8: capture and read of the same bit in one cycle.
        @(negedge clk) pkt_entry = 1'b1;
        @(negedge clk) pkt_entry = 1'b0;
        err_flags = 15'h0008; sens_mask = 15'h7fff; pkt_exit = 1'b1;
        host_rd = 1'b1; rd_idx = 4'd3;
        @(negedge clk) pkt_exit = 1'b0; host_rd = 1'b0;
        chk("R8 set wins", 1'b0);
        hread(4'd3);
        chk("R8 later read clears", 1'b1);

        // R9: back to live mode, pending emptied, then sticky again.
        field(15'h0040, 15'h7fff);
        chk("R9 sticky low before switch", 1'b0);
        @(negedge clk) sticky_en = 1'b0;
        @(negedge clk) sticky_en = 1'b1;
        @(negedge clk);
        chk("R9 pending emptied in live mode", 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule